// File: doc/BRIEF.md
# Run-Time Adjustable Sample Delay Line

This block holds back a stream of signed audio samples by a number of sample periods chosen at run time. It suits modulation effects such as vibrato, where an external oscillator changes the delay value while samples keep flowing. Each accepted sample goes into a circular store whose depth is a power of two. A single pointer supplies the write location and moves forward one place per accepted sample. The read location is that pointer minus an offset, and the subtraction wraps within the store. The store has a synchronous read, which costs one clock. To make up for that clock, the offset is the requested delay less one.

A two-state controller tracks how full the store is. It starts in FILL and moves to RUN once every location has been written. While in FILL, a read that reaches back past the first sample after reset returns silence. In RUN, every read returns stored data. A change to the delay value does not clear the store. The new value applies to the next accepted sample.

Top module: `vd_line`

## Requirements
- R1: While reset is held and on the first cycle after it is released, out_valid is 0 and out_data is 0.
- R2: out_valid in a cycle equals in_valid in the previous cycle.
- R3: Number the accepted samples n = 0, 1, 2, ... from reset. Take a clamped delay D in 1..DEPTH, where DEPTH is 64 by default. The cycle after sample n is accepted, out_data equals accepted sample n-D+1. With D = 1 this is sample n itself, passed through the read bypass.
- R4: If n-D+1 is negative, the output for sample n is 0.
- R5: A requested delay of 0 behaves as a delay of 1.
- R6: A requested delay above DEPTH behaves as DEPTH. The bench uses 65, 66, 200 and 255.
- R7: Cycles with in_valid low do not advance the write pointer, do not write the store, and leave out_data unchanged.
- R8: The delay value is sampled on each accepted sample. Changing it keeps the stored samples, so the output follows R3 with the new D from the next accepted sample onward.
- R9: The controller leaves FILL for RUN on the accepted sample written to the last location, which is sample DEPTH-1. It never returns to FILL before the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample accepted this cycle |
| in_data | input | DATA_W (16) | Signed two's-complement input sample |
| delay_req | input | DLY_W (8) | Requested delay in samples; clamped to 1..DEPTH |
| out_valid | output | 1 | Output sample valid, in_valid delayed one cycle |
| out_data | output | DATA_W (16) | Signed delayed sample |

## Verification
The bench sweeps every requested delay from 0 to 66 and also 200 and 255. Each run starts from reset, so it covers the zero-fill at the start, the D = 1 read bypass, the D = DEPTH reach to the location just ahead of the pointer, and both clamps. A design without the minus-one compensation would be off by one sample at every delay. One that used the write location without a bypass at D = 1 would output stale or zero data. Idle cycles are mixed into the stream. A pointer that advanced on those cycles would shift every later expected value. A second run changes the delay every few samples without a reset. A design that cleared or masked the store on a change, or that went back to zero-fill after the wrap, would output zeros where old samples belong.

// File: rtl/vd_pkg.sv
package vd_pkg;
    typedef enum logic [0:0] {
        VD_FILL = 1'b0,
        VD_RUN  = 1'b1
    } vd_phase_e;
endpackage

// File: rtl/vd_delay_ctrl.sv
module vd_delay_ctrl #(
    parameter int ADDR_W = 6,
    parameter int DLY_W  = 8
) (
    input  logic [DLY_W-1:0]  delay_req,
    output logic [ADDR_W-1:0] rd_off
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DLY_W-1:0] DLY_MAX = DLY_W'(DEPTH);

    logic [DLY_W-1:0] dly_m1;
    assign dly_m1 = delay_req - DLY_W'(1);

    // clamp to 1..DEPTH (R5, R6), then subtract one for read latency
    always_comb begin
        if (delay_req == '0)
            rd_off = '0;
        else if (delay_req > DLY_MAX)
            rd_off = ADDR_W'(DEPTH - 1);
        else
            rd_off = dly_m1[ADDR_W-1:0];
    end
endmodule

// File: rtl/vd_wr_pointer.sv
module vd_wr_pointer
    import vd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [ADDR_W-1:0] rd_off,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              silent
);
    localparam logic [ADDR_W-1:0] PTR_LAST = '1;

    vd_phase_e phase_q, phase_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= VD_FILL;
            wr_ptr  <= '0;
        end else begin
            phase_q <= phase_d;
            if (adv) wr_ptr <= wr_ptr + ADDR_W'(1);
        end
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            VD_FILL: if (adv && wr_ptr == PTR_LAST) phase_d = VD_RUN;
            VD_RUN:  phase_d = VD_RUN;
            default: phase_d = VD_FILL;
        endcase
    end

    always_comb begin
        rd_addr = wr_ptr - rd_off;
        unique case (phase_q)
            VD_FILL: silent = (rd_off > wr_ptr);
            VD_RUN:  silent = 1'b0;
            default: silent = 1'b1;
        endcase
    end

    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> wr_ptr == $past(wr_ptr) + ADDR_W'(1));
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(wr_ptr));
    p_run_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == VD_RUN |=> phase_q == VD_RUN);
endmodule

// File: rtl/vd_sample_store.sv
module vd_sample_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic signed [DATA_W-1:0] rd_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic signed [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wr_addr] <= wr_data;
    end

    // read port never writes; same-address read returns new data
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (we)
            rd_q <= (rd_addr == wr_addr) ? wr_data : mem[rd_addr];
    end

    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rd_addr == wr_addr) |=> rd_q == $past(wr_data));
endmodule

// File: rtl/vd_line.sv
module vd_line #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    parameter int DLY_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic [DLY_W-1:0]         delay_req,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);
    logic [ADDR_W-1:0]        rd_off, wr_ptr, rd_addr;
    logic                     silent, silent_q;
    logic signed [DATA_W-1:0] rd_q;

    vd_delay_ctrl #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) ctrl_i (
        .delay_req(delay_req),
        .rd_off   (rd_off)
    );

    vd_wr_pointer #(.ADDR_W(ADDR_W)) ptr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (in_valid),
        .rd_off (rd_off),
        .wr_ptr (wr_ptr),
        .rd_addr(rd_addr),
        .silent (silent)
    );

    vd_sample_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (in_valid),
        .wr_addr(wr_ptr),
        .wr_data(in_data),
        .rd_addr(rd_addr),
        .rd_q   (rd_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            silent_q  <= 1'b1;
        end else begin
            out_valid <= in_valid;
            if (in_valid) silent_q <= silent;
        end
    end

    assign out_data = silent_q ? '0 : rd_q;

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

// File: tb/vd_line_tb_top.sv
module vd_line_tb_top;
    localparam int DW = 16;
    localparam int AW = 6;
    localparam int LW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic [LW-1:0] delay_req = '0;
    logic out_valid;
    logic signed [DW-1:0] out_data;

    always #5 clk = ~clk;

    vd_line #(.DATA_W(DW), .ADDR_W(AW), .DLY_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .delay_req(delay_req), .out_valid(out_valid), .out_data(out_data)
    );

    int checks = 0;
    int fails = 0;
    int k = 0;
    logic signed [DW-1:0] hist [4096];
    logic signed [DW-1:0] last_out = '0;
    bit done = 0;

    function automatic int clampd(int d);
        if (d == 0) return 1;
        if (d > DEPTH) return DEPTH;
        return d;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(out_data == 0, "R1 data", int'(out_data), 0);
        k = 0; last_out = '0;
    endtask

    task automatic step(bit v, int d);
        int dc, src;
        logic signed [DW-1:0] x, e;
        x = DW'(k * 613 + 7) ^ 16'h5A00;
        in_valid = v; in_data = x; delay_req = LW'(d);
        @(negedge clk);
        chk(out_valid == v, "R2 valid follow", int'(out_valid), int'(v));
        if (v) begin
            hist[k] = x;
            dc = clampd(d);
            src = k - dc + 1;
            e = (src >= 0) ? hist[src] : '0;
            // R3 delay, R4 zero fill, R5/R6 clamp, R8 change, R9 after wrap
            chk(out_data == e, "R3/R4/R5/R6/R8/R9 data", int'(out_data), int'(e));
            k++;
        end else begin
            chk(out_data == last_out, "R7 idle hold", int'(out_data), int'(last_out));
        end
        last_out = out_data;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int d = 0; d < 70; d++) begin
            int dd;
            dd = (d <= 66) ? d : ((d == 67) ? 200 : 255);
            do_reset();
            for (int i = 0; i < 90; i++) begin
                step(1'b1, dd);
                if (i % 7 == 3) step(1'b0, dd);
            end
        end
        // R8: delay changes without reset; R9 wrap retained
        do_reset();
        for (int j = 0; j < 400; j++) begin
            step(1'b1, ((j / 9) * 7) % 70);
            if (j % 11 == 5) step(1'b0, 3);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule